// File: doc/BRIEF.md
# Paired-Entry Drum Command Queue

This block sits between a host processor and a drum transfer sequencer. The host writes 36-bit command words one at a time into a 16-slot circular store. Each drum operation is two consecutive words. The first is a function word carrying sector, track, drum select, operation code, interrupt level and a sequence tag. The second is an address and count word. The sequencer sees the word pair at the head of the queue. The fields of the head function word are already split out for it. When it has finished with an operation, it retires both slots together in one cycle.

A status word shows the host whether there is room for another command, whether the queue has drained, and whether a write was ever lost. The status conditions compare pointers with offsets of zero, one and two slots, not with a plain occupancy count. This reflects the two-slot grain of a command. The status word also returns the sequence tag of the most recently retired command, so the host can tell which operation completed.

Top module: `drum_cmd_queue`

## Requirements
- R1: The store holds 16 words. The write pointer and the head pointer both wrap from 15 to 0, and a word written after a wrap is presented at the head in the order it was written.
- R2: When `wr_en` is high and the write pointer plus one (mod 16) differs from the head pointer, `wr_data` is stored at the write pointer and the write pointer advances by one at that clock edge.
- R3: A write that arrives when the write pointer plus one equals the head pointer leaves the store and the pointers unchanged. It sets the queue-full bit, `stat_word[2]`, which stays set until reset.
- R4: The ready bit, `stat_word[0]`, is 1 exactly when the head pointer differs from the write pointer plus two (mod 16). It is therefore 0 when 14 words are queued.
- R5: The busy bit, `stat_word[1]`, is 1 exactly when the head pointer equals the write pointer, that is, when nothing is queued.
- R6: `hd_valid` is 1 when at least two words are queued. A `retire` pulse while `hd_valid` is 1 advances the head pointer by two (mod 16).
- R7: A `retire` pulse while fewer than two words are queued has no effect on the pointers, the status word or the latched tag.
- R8: `hd_func_word` is the word at the head pointer and `hd_xfer_word` is the word in the next slot. The head function word is split as follows: sector is bits 6:2, track is bits 16:7, drum select is bits 18:17, operation code is bits 20:19, interrupt level is bits 23:21 and sequence tag is bits 29:24.
- R9: When a command is retired, its sequence tag is latched. The status word returns the latched tag in bits 30:25, and all status bits not named here read 0.
- R10: Reset clears both pointers, the queue-full bit and the latched tag. After reset the status word reads 3 (ready and busy) and `hd_valid` is 0.
- R11: A write and a retire in the same cycle both take effect. The full test uses the head pointer as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 36 | Host command word |
| retire | input | 1 | Sequencer retires the head command pair |
| hd_valid | output | 1 | A full command pair is at the head |
| hd_func_word | output | 36 | Word at the head pointer |
| hd_xfer_word | output | 36 | Word after the head pointer |
| hd_sector | output | 5 | Sector field of the head function word |
| hd_track | output | 10 | Track field of the head function word |
| hd_disk | output | 2 | Drum select field of the head function word |
| hd_func | output | 2 | Operation code field of the head function word |
| hd_prio | output | 3 | Interrupt level field of the head function word |
| hd_seq | output | 6 | Sequence tag field of the head function word |
| stat_word | output | 36 | Host status: ready, busy, queue full, latched tag |

## Verification
Several properties are checked on every cycle:
- a refused write never moves the write pointer;
- an accepted write moves it by exactly one;
- the head pointer moves by two on a valid retire and holds otherwise;
- the queue-full bit never clears outside reset;
- the latched tag follows the retired head.

Other behaviour can only be shown by the bench's scenarios. These include the exact occupancy at which ready drops, the order of words across the wrap, the field split of a known function word, the same-cycle write and retire, and the values after a reset in the middle of a run. The bench runs these scenarios against its own queue model.

// File: rtl/drum_cmdq_pkg.sv
package drum_cmdq_pkg;

   // Function word field layout (the sequencer decodes these positions)
   localparam int SEC_LSB  = 2;
   localparam int SEC_W    = 5;
   localparam int TRK_LSB  = 7;
   localparam int TRK_W    = 10;
   localparam int DSK_LSB  = 17;
   localparam int DSK_W    = 2;
   localparam int FN_LSB   = 19;
   localparam int FN_W     = 2;
   localparam int PRI_LSB  = 21;
   localparam int PRI_W    = 3;
   localparam int SEQ_LSB  = 24;
   localparam int SEQ_W    = 6;

   // Host status word layout
   localparam int STAT_RDY     = 0;
   localparam int STAT_BSY     = 1;
   localparam int STAT_QF      = 2;
   localparam int STAT_SEQ_LSB = 25;

   typedef struct packed {
      logic [SEC_W-1:0] sector;
      logic [TRK_W-1:0] track;
      logic [DSK_W-1:0] disk;
      logic [FN_W-1:0]  func;
      logic [PRI_W-1:0] prio;
      logic [SEQ_W-1:0] seq;
   } cmd_fields_t;

endpackage

// File: rtl/cmdq_ptrs.sv
module cmdq_ptrs #(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             retire,
   output logic [PTR_W-1:0] put_ptr,
   output logic [PTR_W-1:0] take_ptr,
   output logic             wr_accept,
   output logic             pair_avail,
   output logic             rdy,
   output logic             bsy,
   output logic             qfull
);

   localparam logic [PTR_W-1:0] STEP1 = PTR_W'(1);
   localparam logic [PTR_W-1:0] STEP2 = PTR_W'(2);

   logic [PTR_W-1:0] occupancy;
   logic             no_room;
   logic             take_go;

   assign occupancy  = put_ptr - take_ptr;
   assign no_room    = (put_ptr + STEP1) == take_ptr;
   assign wr_accept  = wr_en && !no_room;
   assign pair_avail = (occupancy != '0) && (occupancy != STEP1);
   assign take_go    = retire && pair_avail;
   assign rdy        = take_ptr != (put_ptr + STEP2);
   assign bsy        = take_ptr == put_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         put_ptr  <= '0;
         take_ptr <= '0;
         qfull    <= 1'b0;
      end else begin
         if (wr_accept)
            put_ptr <= put_ptr + STEP1;
         if (wr_en && no_room)
            qfull <= 1'b1;
         if (take_go)
            take_ptr <= take_ptr + STEP2;
      end
   end

   AST_PUT_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((put_ptr + STEP1) == take_ptr)) |=> $stable(put_ptr)); // R3

   AST_QF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      qfull |=> qfull); // R3

   AST_PUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |=> (put_ptr == $past(put_ptr) + STEP1)); // R2

   AST_TAKE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && pair_avail) |=> (take_ptr == $past(take_ptr) + STEP2)); // R6

   AST_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !pair_avail) |=> $stable(take_ptr)); // R7

endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 36,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_accept,
   input  logic [PTR_W-1:0]  put_ptr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  take_ptr,
   output logic [WORD_W-1:0] rd_head,
   output logic [WORD_W-1:0] rd_next
);

   logic [WORD_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]  next_idx;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_accept && (put_ptr == PTR_W'(gi)))
            slot[gi] <= wr_data;
      end
   end

   assign next_idx = take_ptr + PTR_W'(1);
   assign rd_head  = slot[take_ptr];
   assign rd_next  = slot[next_idx];

endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
   import drum_cmdq_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic [WORD_W-1:0] word,
   output cmd_fields_t       fields
);

   logic unused_bits;

   assign fields.sector = word[SEC_LSB +: SEC_W];
   assign fields.track  = word[TRK_LSB +: TRK_W];
   assign fields.disk   = word[DSK_LSB +: DSK_W];
   assign fields.func   = word[FN_LSB  +: FN_W];
   assign fields.prio   = word[PRI_LSB +: PRI_W];
   assign fields.seq    = word[SEQ_LSB +: SEQ_W];

   assign unused_bits = ^{word[WORD_W-1:SEQ_LSB+SEQ_W], word[SEC_LSB-1:0]};

endmodule

// File: rtl/drum_cmd_queue.sv
module drum_cmd_queue
   import drum_cmdq_pkg::*;
#(
   parameter int WORD_W = 36,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              retire,
   output logic              hd_valid,
   output logic [WORD_W-1:0] hd_func_word,
   output logic [WORD_W-1:0] hd_xfer_word,
   output logic [SEC_W-1:0]  hd_sector,
   output logic [TRK_W-1:0]  hd_track,
   output logic [DSK_W-1:0]  hd_disk,
   output logic [FN_W-1:0]   hd_func,
   output logic [PRI_W-1:0]  hd_prio,
   output logic [SEQ_W-1:0]  hd_seq,
   output logic [WORD_W-1:0] stat_word
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (WORD_W < STAT_SEQ_LSB + SEQ_W) begin : g_bad_width
      $error("WORD_W too narrow for status tag field");
   end

   logic [PTR_W-1:0] put_ptr;
   logic [PTR_W-1:0] take_ptr;
   logic             wr_accept;
   logic             rdy;
   logic             bsy;
   logic             qfull;
   logic [SEQ_W-1:0] done_seq;
   cmd_fields_t      head_f;

   cmdq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .retire     (retire),
      .put_ptr    (put_ptr),
      .take_ptr   (take_ptr),
      .wr_accept  (wr_accept),
      .pair_avail (hd_valid),
      .rdy        (rdy),
      .bsy        (bsy),
      .qfull      (qfull)
   );

   cmdq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
      .clk       (clk),
      .wr_accept (wr_accept),
      .put_ptr   (put_ptr),
      .wr_data   (wr_data),
      .take_ptr  (take_ptr),
      .rd_head   (hd_func_word),
      .rd_next   (hd_xfer_word)
   );

   cmdq_decode #(.WORD_W(WORD_W)) u_dec (
      .word   (hd_func_word),
      .fields (head_f)
   );

   assign hd_sector = head_f.sector;
   assign hd_track  = head_f.track;
   assign hd_disk   = head_f.disk;
   assign hd_func   = head_f.func;
   assign hd_prio   = head_f.prio;
   assign hd_seq    = head_f.seq;

   always_ff @(posedge clk) begin
      if (!rst_n)
         done_seq <= '0;
      else if (retire && hd_valid)
         done_seq <= head_f.seq;
   end

   always_comb begin
      stat_word = '0;
      stat_word[STAT_RDY] = rdy;
      stat_word[STAT_BSY] = bsy;
      stat_word[STAT_QF]  = qfull;
      stat_word[STAT_SEQ_LSB +: SEQ_W] = done_seq;
   end

   AST_SEQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && hd_valid) |=> (stat_word[STAT_SEQ_LSB +: SEQ_W] == $past(hd_seq))); // R9

   AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(retire && hd_valid)) |=> $stable(stat_word[STAT_SEQ_LSB +: SEQ_W])); // R7

endmodule

// File: tb/drum_cmd_queue_tb.sv
module drum_cmd_queue_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [35:0] wr_data = '0;
   logic        retire = 1'b0;
   logic        hd_valid;
   logic [35:0] hd_func_word, hd_xfer_word, stat_word;
   logic [4:0]  hd_sector;
   logic [9:0]  hd_track;
   logic [1:0]  hd_disk, hd_func;
   logic [2:0]  hd_prio;
   logic [5:0]  hd_seq;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   drum_cmd_queue u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .retire(retire), .hd_valid(hd_valid), .hd_func_word(hd_func_word),
      .hd_xfer_word(hd_xfer_word), .hd_sector(hd_sector), .hd_track(hd_track),
      .hd_disk(hd_disk), .hd_func(hd_func), .hd_prio(hd_prio), .hd_seq(hd_seq),
      .stat_word(stat_word)
   );

   // independent queue model
   logic [35:0] m_mem [16];
   int m_put = 0, m_take = 0;
   bit m_qf = 0;
   logic [5:0] m_seq = '0;

   typedef struct packed {
      logic        wr;
      logic        rt;
      logic [35:0] d;
      logic        rdy;
      logic        bsy;
      logic        v;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b1, 1'b0, 36'h015A5A5A4, 1'b1, 1'b0, 1'b0},
      '{1'b0, 1'b1, 36'h000000000, 1'b1, 1'b0, 1'b0},
      '{1'b1, 1'b0, 36'h000000100, 1'b1, 1'b0, 1'b1},
      '{1'b1, 1'b0, 36'h023456789, 1'b1, 1'b0, 1'b1},
      '{1'b1, 1'b1, 36'h03F000000, 1'b1, 1'b0, 1'b1},
      '{1'b0, 1'b1, 36'h000000000, 1'b1, 1'b1, 1'b0}
   };

   task automatic check(input string req, input string what,
                        input logic [35:0] got, input logic [35:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic compare_model();
      int cnt;
      cnt = (m_put - m_take) & 15;
      check("R4", "ready", {35'd0, stat_word[0]}, {35'd0, m_take != ((m_put + 2) & 15)});
      check("R5", "busy", {35'd0, stat_word[1]}, {35'd0, m_take == m_put});
      check("R3", "qfull", {35'd0, stat_word[2]}, {35'd0, m_qf});
      check("R9", "tag", {30'd0, stat_word[30:25]}, {30'd0, m_seq});
      check("R9", "spare bits", {stat_word[35:31], stat_word[24:3]}, '0);
      check("R6", "valid", {35'd0, hd_valid}, {35'd0, cnt >= 2});
      if (cnt >= 2) begin
         check("R1", "head word", hd_func_word, m_mem[m_take]);
         check("R8", "xfer word", hd_xfer_word, m_mem[(m_take + 1) & 15]);
      end
   endtask

   task automatic step(input logic w, input logic r, input logic [35:0] d);
      int cnt;
      bit full;
      @(negedge clk);
      wr_en = w; retire = r; wr_data = d;
      @(posedge clk);
      cnt  = (m_put - m_take) & 15;
      full = ((m_put + 1) & 15) == m_take;
      if (r && cnt >= 2) begin
         m_seq  = m_mem[m_take][29:24];
         m_take = (m_take + 2) & 15;
      end
      if (w) begin
         if (!full) begin
            m_mem[m_put] = d;
            m_put = (m_put + 1) & 15;
         end else
            m_qf = 1;
      end
      @(negedge clk);
      wr_en = 0; retire = 0;
      compare_model();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; wr_en = 0; retire = 0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      m_put = 0; m_take = 0; m_qf = 0; m_seq = '0;
      check("R10", "status after reset", stat_word, 36'd3);
      check("R10", "valid after reset", {35'd0, hd_valid}, '0);
   endtask

   function automatic logic [35:0] mkcmd(int sec, int trk, int dsk, int fn, int pr, int sq);
      logic [35:0] w;
      w = '0;
      w[6:2] = 5'(sec); w[16:7] = 10'(trk); w[18:17] = 2'(dsk);
      w[20:19] = 2'(fn); w[23:21] = 3'(pr); w[29:24] = 6'(sq);
      return w;
   endfunction

   initial begin
      repeat (2) @(posedge clk);
      do_reset();

      // vector table: R2, R6, R7, R11
      for (int i = 0; i < 6; i++) begin
         step(VECS[i].wr, VECS[i].rt, VECS[i].d);
         check("R4", $sformatf("vec%0d ready", i), {35'd0, stat_word[0]}, {35'd0, VECS[i].rdy});
         check("R5", $sformatf("vec%0d busy", i), {35'd0, stat_word[1]}, {35'd0, VECS[i].bsy});
         check("R6", $sformatf("vec%0d valid", i), {35'd0, hd_valid}, {35'd0, VECS[i].v});
      end
      // after vec 4 (write+retire, R11) and vec 5 the tag is that of the third command word
      check("R11", "tag after paired ops", {30'd0, stat_word[30:25]}, 36'h23);

      // field decode, R8
      do_reset();
      step(1, 0, mkcmd(19, 613, 2, 1, 5, 42));
      step(1, 0, 36'h0FFFC0123);
      check("R8", "sector", {31'd0, hd_sector}, 36'd19);
      check("R8", "track", {26'd0, hd_track}, 36'd613);
      check("R8", "disk", {34'd0, hd_disk}, 36'd2);
      check("R8", "func", {34'd0, hd_func}, 36'd1);
      check("R8", "prio", {33'd0, hd_prio}, 36'd5);
      check("R8", "seq", {30'd0, hd_seq}, 36'd42);
      step(0, 1, '0);
      check("R9", "latched tag", {30'd0, stat_word[30:25]}, 36'd42);
      check("R7", "retire on empty", {35'd0, stat_word[1]}, 36'd1);
      step(0, 1, '0);
      check("R7", "tag unchanged", {30'd0, stat_word[30:25]}, 36'd42);

      // fill to full, R4 and R3 (pointers now at 2)
      for (int i = 0; i < 14; i++) step(1, 0, mkcmd(i, i * 3, 0, 2, 1, i + 1));
      check("R4", "ready low at 14", {35'd0, stat_word[0]}, 36'd0);
      step(1, 0, mkcmd(14, 7, 1, 1, 1, 15));
      check("R4", "ready back at 15", {35'd0, stat_word[0]}, 36'd1);
      check("R3", "no qfull yet", {35'd0, stat_word[2]}, 36'd0);
      step(1, 0, 36'hBADBADBAD);
      check("R3", "qfull set", {35'd0, stat_word[2]}, 36'd1);
      // drain across wrap and refill, R1
      for (int i = 0; i < 5; i++) step(0, 1, '0);
      for (int i = 0; i < 8; i++) step(1, (i % 3) == 0, mkcmd(i, 900 + i, 3, 0, 7, 50 + i));
      for (int i = 0; i < 10; i++) step(0, 1, '0);
      check("R3", "qfull still sticky", {35'd0, stat_word[2]}, 36'd1);

      // reset mid-run, R10
      step(1, 0, 36'h111111111);
      do_reset();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule